// File: doc/BRIEF.md
# E1 National Bits Capture

This block sits on the receive side of an E1 framer. It watches the incoming bit stream and gathers the five national-use spare bits from timeslot 0 of the odd frames of each 16-frame multiframe. Those odd frames are the ones that do not carry the alignment word. Each spare-bit position is assembled into its own byte, so one byte holds the eight successive values of that bit across one multiframe.

The bits are gathered into a shadow bank while the multiframe is in progress. All five bytes are copied into readable holding registers in one step, when the final bit of frame 15 is accepted. Software or a neighbouring block reads the holding registers through a small combinational read port. It places a 4-bit index on the port and gets a 16-bit word back. Multiframe alignment is done upstream. The block relies on an external frame number and on a marker that flags the first bit of frame 0.

Top module: `e1_natbit_capture`

## Requirements
- R1: After a synchronous active-low reset, every index of the read port returns 16'h0000.
- R2: Read index 0, 1, 2, 3 and 4 returns the byte gathered from frame bit position 3, 4, 5, 6 and 7 respectively (the national bits Sa4 to Sa8). Positions are counted from 0 at the first accepted bit of each frame.
- R3: Within a byte, the bit from frame 2k+1 lands in byte bit 7-k. Frame 1 therefore fills the MSB and frame 15 fills the LSB.
- R4: Bits at positions 3 to 7 of even-numbered frames (frame_num bit 0 clear) have no effect on any captured byte.
- R5: Bits at positions other than 3 to 7 have no effect on any captured byte.
- R6: The readable bytes change only on the clock edge that accepts the last bit position of frame 15. Before that edge the previous multiframe's bytes are returned, and after it all five new bytes are returned together.
- R7: Bits 15 to 8 of the read data are always zero.
- R8: Read indices 5 to 15 return 16'h0000.
- R9: While rx_bit_en is low, rx_bit and mf_start are ignored and the bit position does not advance.
- R10: A bit accepted with mf_start high is taken as position 0, and the position count restarts from there. This realigns the block to the stream at any point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Received serial data bit |
| rx_bit_en | input | 1 | High when rx_bit carries a valid bit this cycle |
| mf_start | input | 1 | High with the first bit of frame 0 of a multiframe |
| frame_num | input | 4 | Frame index of the current bit within the multiframe (0 to 15) |
| rd_idx | input | 4 | Read register index |
| rd_data | output | 16 | Read data for rd_idx (combinational) |

## Verification
The bench builds the block with a 16-bit frame (FRAME_BITS = 16) instead of 256. All other parameters stay at their defaults. The shorter frame keeps every timeslot-0 bit position and the full 16-frame, five-byte layout intact, and a complete multiframe takes 256 bit cycles. This leaves room for several back-to-back multiframes, idle gaps with garbage on the inputs, and a mid-frame realignment within the run. It also lets the bench check the frame-15 hand-over both just before and just after the committing edge.

// File: rtl/natbit_pkg.sv
// Package: natbit_pkg
// Shared constants and helpers for the national-bit capture block.
// Assumes a multiframe of an even number of frames whose odd frames
// carry the national bits.
package natbit_pkg;

    // Width of the word returned by the read port.
    localparam int unsigned RD_WORD_W = 16;

    // Map an odd frame number 2k+1 to the byte bit it fills (7-k style,
    // generalised to a byte of width byte_w).
    function automatic int unsigned byte_bit_of_slot(input int unsigned slot,
                                                     input int unsigned byte_w);
        return byte_w - 1 - slot;
    endfunction

endpackage

// File: rtl/natbit_pos_tracker.sv
// Module: natbit_pos_tracker
// Tracks the bit position inside the current frame. A bit accepted with
// mf_start high is position 0; each accepted bit advances the count,
// wrapping after FRAME_BITS positions. Assumes mf_start is only
// meaningful together with bit_en.
module natbit_pos_tracker #(
    parameter int unsigned FRAME_BITS = 256,
    parameter int unsigned POS_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             mf_start,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] cnt,
    output logic             last_pos
);

    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

    // Position of the bit presented this cycle (realigned by mf_start).
    always_comb begin
        pos      = mf_start ? '0 : cnt;
        last_pos = (pos == LAST);
    end

    // Advance the stored position on every accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (bit_en) begin
            cnt <= last_pos ? '0 : pos + POS_W'(1);
        end
    end

endmodule

// File: rtl/natbit_shadow_bank.sv
// Module: natbit_shadow_bank
// Holds the in-progress national bits. Each of NUM_SA bit positions of
// timeslot 0 owns a byte. In odd frame 2k+1 the bit at position
// FIRST_POS+s is written to byte s, bit (SA_W-1-k). Even frames and
// other positions are left alone. Assumes SA_W equals half the frames.
module natbit_shadow_bank
    import natbit_pkg::*;
#(
    parameter int unsigned NUM_SA    = 5,
    parameter int unsigned SA_W      = 8,
    parameter int unsigned FIRST_POS = 3,
    parameter int unsigned POS_W     = 8,
    parameter int unsigned FN_W      = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_en,
    input  logic                     rx_bit,
    input  logic [POS_W-1:0]         pos,
    input  logic [FN_W-1:0]          frame_num,
    output logic [NUM_SA*SA_W-1:0]   shadow_flat
);

    localparam int unsigned SLOT_W = FN_W - 1;

    logic             odd_frame;
    logic [SLOT_W-1:0] slot;

    // Split the frame number into odd flag and odd-frame slot index.
    always_comb begin
        odd_frame = frame_num[0];
        slot      = frame_num[FN_W-1:1];
    end

    for (genvar s = 0; s < NUM_SA; s++) begin : g_sa
        logic hit_pos;

        // True when the current bit is this byte's spare-bit position.
        always_comb hit_pos = bit_en && odd_frame &&
                              (pos == POS_W'(FIRST_POS + s));

        for (genvar k = 0; k < SA_W; k++) begin : g_slot
            localparam int unsigned BB = byte_bit_of_slot(k, SA_W);

            // Capture one bit of byte s from odd frame 2k+1.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shadow_flat[s*SA_W + BB] <= 1'b0;
                end else if (hit_pos && (slot == SLOT_W'(k))) begin
                    shadow_flat[s*SA_W + BB] <= rx_bit;
                end
            end
        end
    end

endmodule

// File: rtl/natbit_hold_regs.sv
// Module: natbit_hold_regs
// Readable copy of the shadow bank. Loads all bytes at once when the
// last bit position of the last frame is accepted. Assumes the shadow
// bank is settled by then (spare bits precede the frame's last bit).
module natbit_hold_regs #(
    parameter int unsigned WIDTH = 40,
    parameter int unsigned FN_W  = 4,
    parameter int unsigned LAST_FRAME = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             last_pos,
    input  logic [FN_W-1:0]  frame_num,
    input  logic [WIDTH-1:0] shadow_flat,
    output logic [WIDTH-1:0] hold_flat
);

    logic commit;

    // End-of-multiframe strobe.
    always_comb commit = bit_en && last_pos &&
                         (frame_num == FN_W'(LAST_FRAME));

    // Copy the shadow bank on the commit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_flat <= '0;
        end else if (commit) begin
            hold_flat <= shadow_flat;
        end
    end

endmodule

// File: rtl/natbit_read_mux.sv
// Module: natbit_read_mux
// Combinational read port. Index s < NUM_SA returns byte s in the low
// bits with the upper bits zero; any other index returns zero.
module natbit_read_mux #(
    parameter int unsigned NUM_SA = 5,
    parameter int unsigned SA_W   = 8,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned RD_W   = 16
) (
    input  logic [NUM_SA*SA_W-1:0] hold_flat,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [RD_W-1:0]        rd_data
);

    // Select the addressed byte, zero-extended.
    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NUM_SA; s++) begin
            if (rd_idx == IDX_W'(s)) begin
                rd_data[SA_W-1:0] = hold_flat[s*SA_W +: SA_W];
            end
        end
    end

endmodule

// File: rtl/e1_natbit_capture.sv
// Module: e1_natbit_capture
// Gathers the national spare bits from timeslot 0 of odd frames over a
// multiframe and exposes them as NUM_SA read-only bytes. Assumes an
// aligned upstream: frame_num is valid with each bit and mf_start
// flags the first bit of frame 0.
module e1_natbit_capture
    import natbit_pkg::*;
#(
    parameter int unsigned FRAME_BITS    = 256,
    parameter int unsigned FRAMES_PER_MF = 16,
    parameter int unsigned NUM_SA        = 5,
    parameter int unsigned FIRST_POS     = 3,
    parameter int unsigned IDX_W         = 4,
    parameter int unsigned FN_W          = $clog2(FRAMES_PER_MF)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_bit,
    input  logic                  rx_bit_en,
    input  logic                  mf_start,
    input  logic [FN_W-1:0]       frame_num,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [RD_WORD_W-1:0]  rd_data
);

    localparam int unsigned POS_W = $clog2(FRAME_BITS);
    localparam int unsigned SA_W  = FRAMES_PER_MF / 2;
    localparam int unsigned BANK_W = NUM_SA * SA_W;

    logic [POS_W-1:0]  bit_pos;
    logic [POS_W-1:0]  bit_cnt;
    logic              last_pos;
    logic [BANK_W-1:0] shadow_flat;
    logic [BANK_W-1:0] hold_flat;

    natbit_pos_tracker #(
        .FRAME_BITS (FRAME_BITS),
        .POS_W      (POS_W)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (rx_bit_en),
        .mf_start (mf_start),
        .pos      (bit_pos),
        .cnt      (bit_cnt),
        .last_pos (last_pos)
    );

    natbit_shadow_bank #(
        .NUM_SA    (NUM_SA),
        .SA_W      (SA_W),
        .FIRST_POS (FIRST_POS),
        .POS_W     (POS_W),
        .FN_W      (FN_W)
    ) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (rx_bit_en),
        .rx_bit      (rx_bit),
        .pos         (bit_pos),
        .frame_num   (frame_num),
        .shadow_flat (shadow_flat)
    );

    natbit_hold_regs #(
        .WIDTH      (BANK_W),
        .FN_W       (FN_W),
        .LAST_FRAME (FRAMES_PER_MF - 1)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (rx_bit_en),
        .last_pos    (last_pos),
        .frame_num   (frame_num),
        .shadow_flat (shadow_flat),
        .hold_flat   (hold_flat)
    );

    natbit_read_mux #(
        .NUM_SA (NUM_SA),
        .SA_W   (SA_W),
        .IDX_W  (IDX_W),
        .RD_W   (RD_WORD_W)
    ) u_rd (
        .hold_flat (hold_flat),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/natbit_capture_chk.sv
// Module: natbit_capture_chk
// Assertion checker bound into e1_natbit_capture.
module natbit_capture_chk #(
    parameter int unsigned FRAME_BITS    = 256,
    parameter int unsigned FRAMES_PER_MF = 16,
    parameter int unsigned NUM_SA        = 5,
    parameter int unsigned IDX_W         = 4,
    parameter int unsigned FN_W          = 4,
    parameter int unsigned POS_W         = 8,
    parameter int unsigned BANK_W        = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_bit_en,
    input logic              mf_start,
    input logic [FN_W-1:0]   frame_num,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [15:0]       rd_data,
    input logic [POS_W-1:0]  bit_pos,
    input logic [POS_W-1:0]  bit_cnt,
    input logic [BANK_W-1:0] hold_flat
);

    // R7
    upper_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:8] == 8'h00);

    // R8
    unused_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx >= IDX_W'(NUM_SA)) |-> (rd_data == 16'h0000));

    // R6
    hold_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_bit_en && (bit_pos == POS_W'(FRAME_BITS - 1)) &&
          (frame_num == FN_W'(FRAMES_PER_MF - 1)))
        |=> $stable(hold_flat));

    // R9
    idle_no_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_bit_en |=> $stable(bit_cnt));

    // R10
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bit_en && mf_start) |=> (bit_cnt == POS_W'(1)));

endmodule

bind e1_natbit_capture natbit_capture_chk #(
    .FRAME_BITS    (FRAME_BITS),
    .FRAMES_PER_MF (FRAMES_PER_MF),
    .NUM_SA        (NUM_SA),
    .IDX_W         (IDX_W),
    .FN_W          (FN_W),
    .POS_W         (POS_W),
    .BANK_W        (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_bit_en (rx_bit_en),
    .mf_start  (mf_start),
    .frame_num (frame_num),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .bit_pos   (bit_pos),
    .bit_cnt   (bit_cnt),
    .hold_flat (hold_flat)
);

// File: tb/e1_natbit_capture_tb.sv
// Directed bench for e1_natbit_capture, built with a 16-bit frame.
module e1_natbit_capture_tb;

    localparam int FB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_bit = 1'b0;
    logic        rx_bit_en = 1'b0;
    logic        mf_start = 1'b0;
    logic [3:0]  frame_num = 4'd0;
    logic [3:0]  rd_idx = 4'd0;
    logic [15:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    e1_natbit_capture #(.FRAME_BITS(FB)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .rx_bit_en (rx_bit_en),
        .mf_start  (mf_start),
        .frame_num (frame_num),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read indices 0..4 and compare with exp (byte i = Sa position i).
    task automatic check_bytes(input logic [39:0] exp, input string req);
        for (int i = 0; i < 5; i++) begin
            rd_idx = 4'(i);
            #1;
            chk(rd_data == {8'h00, exp[8*i +: 8]}, req, rd_data,
                {8'h00, exp[8*i +: 8]});
        end
    endtask

    task automatic drive_bit(input logic b, input logic mf, input int f);
        @(negedge clk);
        rx_bit = b; rx_bit_en = 1'b1; mf_start = mf; frame_num = 4'(f);
    endtask

    task automatic idle(input int n, input logic junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_bit_en = 1'b0; rx_bit = junk; mf_start = junk;
            frame_num = 4'd15;
        end
    endtask

    // One full multiframe. sa byte s = Sa position s. noise fills every
    // non-capturing bit. gaps inserts idle cycles with garbage (R9).
    task automatic run_mf(input logic [39:0] sa, input logic noise,
                          input bit gaps, input logic [39:0] prev,
                          input string req);
        for (int f = 0; f < 16; f++) begin
            for (int p = 0; p < FB; p++) begin
                logic b;
                if ((f % 2 == 1) && p >= 3 && p <= 7)
                    b = sa[8*(p-3) + 7 - (f-1)/2];
                else
                    b = noise ^ logic'(p % 2) ^ logic'(f % 3 == 0);
                drive_bit(b, (f == 0 && p == 0), f);
                if (f == 15 && p == FB-1) begin
                    // R6: before the committing edge, old bytes remain.
                    check_bytes(prev, "R6 hold-before-commit");
                end else if (gaps && (p % 5 == 2)) begin
                    idle(2, ~b);
                end
            end
        end
        idle(1, 1'b0);
        check_bytes(sa, req);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            chk(rd_data == 16'h0, "R1 reset", rd_data, 16'h0);
        end
    endtask

    task automatic t_unused();
        for (int i = 5; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            chk(rd_data == 16'h0, "R8 unused index", rd_data, 16'h0);
        end
        for (int i = 0; i < 5; i++) begin
            rd_idx = 4'(i);
            #1;
            chk(rd_data[15:8] == 8'h0, "R7 upper byte", rd_data, 16'h0);
        end
    endtask

    task automatic t_realign(input logic [39:0] sa, input logic [39:0] prev);
        // Partial garbage frame, then a fresh multiframe resynced by
        // mf_start mid-count (R10).
        for (int i = 0; i < 5; i++) drive_bit(1'b1, 1'b0, 3);
        run_mf(sa, 1'b1, 1'b0, prev, "R10 realign");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();                                                    // R1
        run_mf(40'h81_0F_F0_3C_A5, 1'b1, 1'b0, 40'h0,
               "R2 R3 R4 R5 pattern A");
        run_mf(40'h5A_C3_0F_F0_7E, 1'b0, 1'b1, 40'h81_0F_F0_3C_A5,
               "R9 gaps pattern B");
        run_mf(40'h01_02_40_00_80, 1'b1, 1'b0, 40'h5A_C3_0F_F0_7E,
               "R3 bit order");
        t_realign(40'h33_CC_55_AA_E1, 40'h01_02_40_00_80);
        t_unused();                                                   // R7 R8
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule